// File: doc/BRIEF.md
# Reset Output Pulse Generator

This block drives an active-low reset output whenever one of three reset events is raised: a watchdog overflow, a software warm reset or a software cold reset. The length of the low pulse depends on which event caused it. A watchdog pulse lasts a fixed base of 6 clock cycles plus a programmable number of extra cycles. Both software resets use their own fixed lengths and ignore the programmable value. With a 50 ns system clock, a watchdog pulse therefore lasts 300 ns + 50 ns × field, a warm pulse lasts 750 ns and a cold pulse lasts 800 ns.

The programmable 8-bit duration field sits in a small register. A single-cycle write strobe loads it. The field is captured when a pulse begins, so a write made during a pulse only affects later pulses. A busy flag mirrors the active pulse. Events that arrive while a pulse is running are dropped. The watchdog prescaler and the overflow counter are outside this block; only the overflow indication arrives here.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, `rst_out_n_o` is 1 and `busy_o` is 0, and the duration field holds 6, so the first watchdog pulse after reset lasts 12 cycles.
- R2: With no event and no active pulse, `rst_out_n_o` stays 1 and `busy_o` stays 0.
- R3: A watchdog event sampled while idle drives `rst_out_n_o` low from that same clock edge for exactly 6 + field cycles. The field is the 8-bit value 0..255, so the pulse ranges from 6 to 261 cycles.
- R4: A software warm event sampled while idle gives a low pulse of exactly 15 cycles, whatever the field holds.
- R5: A software cold event sampled while idle gives a low pulse of exactly 16 cycles, whatever the field holds.
- R6: When several events are sampled in the same idle cycle, cold takes precedence over warm, and warm takes precedence over watchdog. The pulse length is the length of the winning source.
- R7: Events sampled while a pulse is active are ignored. They neither lengthen nor restart the pulse, and no pulse follows once they are removed.
- R8: The field is captured at the edge that starts a pulse. A write in the same cycle as the start, or during the pulse, leaves that pulse unchanged, and the written value sets the length of the next watchdog pulse.
- R9: `busy_o` is 1 in exactly the cycles in which `rst_out_n_o` is 0.
- R10: After a pulse ends, `rst_out_n_o` is high for at least one cycle. An event held without a break produces pulses separated by exactly one high cycle.
- R11: A write with `dur_we_i` high stores `dur_wdata_i` in the duration field. That value is seen only through the length of later watchdog pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wdog_ovf_i | input | 1 | Watchdog overflow event |
| sw_warm_i | input | 1 | Software warm reset event |
| sw_cold_i | input | 1 | Software cold reset event |
| dur_we_i | input | 1 | Duration field write strobe |
| dur_wdata_i | input | 8 | Duration field write data |
| rst_out_n_o | output | 1 | Active-low reset output |
| busy_o | output | 1 | High while a pulse is active |

## Verification
A write to the duration field can land in the very cycle in which a watchdog event starts a pulse. The bench provokes this by raising the write strobe and the event together. It then expects the running pulse to use the old field value and the following pulse to use the new one. Several events in one cycle are also driven in all seven combinations, and the measured length is compared against the winning source. Every field value from 0 to 255 is swept, and each measured low time is compared with 6 + value.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_WDOG = 2'd1,
    SRC_WARM = 2'd2,
    SRC_COLD = 2'd3
  } rpg_src_e;
endpackage

// File: rtl/rpg_dur_reg.sv
module rpg_dur_reg #(
  parameter int DUR_W   = 8,
  parameter int DUR_RST = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DUR_W-1:0] wr_data,
  output logic [DUR_W-1:0] dur_o
);
  logic [DUR_W-1:0] dur_q, dur_d;

  always_comb begin
    dur_d = dur_q;
    if (wr_en) dur_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dur_q <= DUR_W'(DUR_RST);
    else if (wr_en) dur_q <= dur_d;
  end

  assign dur_o = dur_q;
endmodule

// File: rtl/rpg_arbiter.sv
module rpg_arbiter
  import rpg_pkg::*;
#(
  parameter int DUR_W     = 8,
  parameter int CNT_W     = 9,
  parameter int WDOG_BASE = 6,
  parameter int WARM_LEN  = 15,
  parameter int COLD_LEN  = 16
) (
  input  logic             ev_wdog,
  input  logic             ev_warm,
  input  logic             ev_cold,
  input  logic [DUR_W-1:0] dur,
  output rpg_src_e         src,
  output logic [CNT_W-1:0] len
);
  always_comb begin
    src = SRC_NONE;
    len = '0;
    if (ev_cold) begin
      src = SRC_COLD;
      len = CNT_W'(COLD_LEN);
    end else if (ev_warm) begin
      src = SRC_WARM;
      len = CNT_W'(WARM_LEN);
    end else if (ev_wdog) begin
      src = SRC_WDOG;
      len = CNT_W'(WDOG_BASE) + CNT_W'(dur);
    end
  end
endmodule

// File: rtl/rpg_timer.sv
module rpg_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy_o,
  output logic             out_n_o
);
  logic             busy_q, busy_d;
  logic             out_n_q, out_n_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!busy_q && start) begin
      busy_d = 1'b1;
      cnt_d  = len - CNT_W'(1);
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
    out_n_d = !busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      out_n_q <= 1'b1;
    end else begin
      busy_q  <= busy_d;
      out_n_q <= out_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o  = busy_q;
  assign out_n_o = out_n_q;
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
  import rpg_pkg::*;
#(
  parameter int DUR_W     = 8,
  parameter int DUR_RST   = 6,
  parameter int WDOG_BASE = 6,
  parameter int WARM_LEN  = 15,
  parameter int COLD_LEN  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdog_ovf_i,
  input  logic             sw_warm_i,
  input  logic             sw_cold_i,
  input  logic             dur_we_i,
  input  logic [DUR_W-1:0] dur_wdata_i,
  output logic             rst_out_n_o,
  output logic             busy_o
);
  localparam int WDOG_MAX = WDOG_BASE + (1 << DUR_W) - 1;
  localparam int SW_MAX   = (WARM_LEN > COLD_LEN) ? WARM_LEN : COLD_LEN;
  localparam int MAX_LEN  = (WDOG_MAX > SW_MAX) ? WDOG_MAX : SW_MAX;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic [DUR_W-1:0] dur_q;
  rpg_src_e         src;
  logic [CNT_W-1:0] len;

  rpg_dur_reg #(.DUR_W(DUR_W), .DUR_RST(DUR_RST)) u_dur (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dur_we_i),
    .wr_data (dur_wdata_i),
    .dur_o   (dur_q)
  );

  rpg_arbiter #(
    .DUR_W(DUR_W), .CNT_W(CNT_W), .WDOG_BASE(WDOG_BASE),
    .WARM_LEN(WARM_LEN), .COLD_LEN(COLD_LEN)
  ) u_arb (
    .ev_wdog (wdog_ovf_i),
    .ev_warm (sw_warm_i),
    .ev_cold (sw_cold_i),
    .dur     (dur_q),
    .src     (src),
    .len     (len)
  );

  rpg_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (src != SRC_NONE),
    .len     (len),
    .busy_o  (busy_o),
    .out_n_o (rst_out_n_o)
  );
endmodule

// File: rtl/rpg_checker.sv
module rpg_checker #(
  parameter int DUR_W     = 8,
  parameter int WDOG_BASE = 6,
  parameter int WARM_LEN  = 15,
  parameter int COLD_LEN  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdog_ovf_i,
  input logic             sw_warm_i,
  input logic             sw_cold_i,
  input logic [DUR_W-1:0] dur_q,
  input logic             rst_out_n_o,
  input logic             busy_o
);
  logic        any_ev;
  logic [15:0] low_cnt;
  logic [15:0] exp_len;

  assign any_ev = wdog_ovf_i || sw_warm_i || sw_cold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      exp_len <= '0;
    end else begin
      if (!rst_out_n_o) low_cnt <= low_cnt + 16'd1;
      else              low_cnt <= '0;
      if (!busy_o && any_ev) begin
        if (sw_cold_i)      exp_len <= 16'(COLD_LEN);
        else if (sw_warm_i) exp_len <= 16'(WARM_LEN);
        else                exp_len <= 16'(WDOG_BASE) + 16'(dur_q);
      end
    end
  end

  p_busy_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == !rst_out_n_o);

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !any_ev) |=> rst_out_n_o);

  p_start_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && any_ev) |=> (!rst_out_n_o && busy_o));

  // Covers R4, R5, R6 and R8 as well: length fixed by source and captured field
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n_o) |-> (low_cnt == exp_len));
endmodule

bind rst_pulse_gen rpg_checker #(
  .DUR_W(DUR_W), .WDOG_BASE(WDOG_BASE), .WARM_LEN(WARM_LEN), .COLD_LEN(COLD_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wdog_ovf_i  (wdog_ovf_i),
  .sw_warm_i   (sw_warm_i),
  .sw_cold_i   (sw_cold_i),
  .dur_q       (dur_q),
  .rst_out_n_o (rst_out_n_o),
  .busy_o      (busy_o)
);

// File: tb/rst_pulse_gen_tb.sv
`timescale 1ns/1ps
module rst_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wdog, warm, cold, we;
  logic [7:0] wd;
  logic       out_n, busy;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  rst_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wdog_ovf_i(wdog), .sw_warm_i(warm),
    .sw_cold_i(cold), .dur_we_i(we), .dur_wdata_i(wd),
    .rst_out_n_o(out_n), .busy_o(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_dur(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0;
  endtask

  // Starts a pulse with the given events; wr_at: -1 none, 0 with the event, k>0 at low cycle k.
  // ev_at > 0 injects a cold event at low cycle ev_at.
  task automatic pulse(input logic w, input logic wa, input logic c, input int exp,
                       input string tag, input int wr_at, input logic [7:0] wr_val,
                       input int ev_at);
    int n;
    bit mis;
    @(negedge clk);
    wdog = w; warm = wa; cold = c;
    if (wr_at == 0) begin we = 1'b1; wd = wr_val; end
    @(negedge clk);
    wdog = 1'b0; warm = 1'b0; cold = 1'b0; we = 1'b0;
    n = 0; mis = 0;
    while (!out_n && n < 400) begin
      if (busy !== 1'b1) mis = 1;
      if (wr_at > 0) begin we = (n == wr_at); wd = wr_val; end
      cold = (ev_at > 0 && n == ev_at);
      n++;
      @(negedge clk);
    end
    we = 1'b0; cold = 1'b0;
    check(n == exp, tag, n, exp);
    check(!mis && busy === 1'b0, "R9 busy mirrors output", int'(busy), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wdog = 0; warm = 0; cold = 0; we = 0; wd = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_n === 1'b1 && busy === 1'b0, "R1 reset state", int'(out_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_n === 1'b1 && busy === 1'b0, "R2 idle high", int'(out_n), 1);
    // R1: default field 6 gives 12 cycles
    pulse(1, 0, 0, 12, "R1 default length", -1, 8'd0, 0);

    // R3 R11: exhaustive sweep of field values
    for (int v = 0; v < 256; v++) begin
      write_dur(8'(v));
      pulse(1, 0, 0, 6 + v, "R3 R11 watchdog length", -1, 8'd0, 0);
    end

    // R4 R5: fixed software lengths for several field values
    for (int k = 0; k < 4; k++) begin
      write_dur(8'(k * 85));
      pulse(0, 1, 0, 15, "R4 warm length", -1, 8'd0, 0);
      pulse(0, 0, 1, 16, "R5 cold length", -1, 8'd0, 0);
    end

    // R6: all event combinations, field 40
    write_dur(8'd40);
    for (int m = 1; m < 8; m++) begin
      pulse(m[0], m[1], m[2], m[2] ? 16 : (m[1] ? 15 : 46), "R6 priority", -1, 8'd0, 0);
    end

    // R8: write during pulse
    write_dur(8'd10);
    pulse(1, 0, 0, 16, "R8 write mid-pulse keeps length", 3, 8'd50, 0);
    pulse(1, 0, 0, 56, "R8 new value on next pulse", -1, 8'd0, 0);
    // R8: write in the start cycle
    write_dur(8'd20);
    pulse(1, 0, 0, 26, "R8 same-cycle write keeps old", 0, 8'd3, 0);
    pulse(1, 0, 0, 9, "R8 same-cycle write next pulse", -1, 8'd0, 0);

    // R7: cold event during a watchdog pulse is ignored
    pulse(1, 0, 0, 9, "R7 event during pulse ignored", -1, 8'd0, 2);
    for (int i = 0; i < 3; i++) begin
      check(out_n === 1'b1, "R7 no pulse after ignored event", int'(out_n), 1);
      @(negedge clk);
    end

    // R10: held event gives exactly one high cycle between pulses
    begin
      int n1, gap;
      @(negedge clk); wdog = 1'b1;
      @(negedge clk);
      n1 = 0;
      while (!out_n && n1 < 400) begin n1++; @(negedge clk); end
      check(n1 == 9, "R10 first held pulse", n1, 9);
      gap = 0;
      while (out_n && gap < 10) begin gap++; @(negedge clk); end
      check(gap == 1, "R10 one high cycle between pulses", gap, 1);
      wdog = 1'b0;
      while (!out_n) @(negedge clk);
    end

    // R1: reset during a pulse restores defaults
    @(negedge clk); warm = 1'b1;
    @(negedge clk); warm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(out_n === 1'b1 && busy === 1'b0, "R1 reset mid-pulse", int'(out_n), 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    pulse(1, 0, 0, 12, "R1 field back to default", -1, 8'd0, 0);
    repeat (3) @(negedge clk);
    check(out_n === 1'b1 && busy === 1'b0, "R2 idle after pulses", int'(out_n), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule